// File: doc/BRIEF.md
# Data-Processing ALU with Flag Logic

This block is the arithmetic and logic stage of a 32-bit integer datapath. It carries out the sixteen data-processing operations on a first operand and a pre-shifted second operand. It returns the result, a write enable for that result and the next values of the four condition flags. Operand selection, the barrel shifter and register writeback sit outside the block. The shifter passes in its carry-out, and the enclosing pipeline passes in the current flags.

The flags follow the operation's class. Logical operations take carry from the shifter and leave overflow alone. Additions report the unsigned carry out of the top bit and the signed overflow. Subtractions report carry as "no borrow". The four compare-type operations always update the flags and never write a result.

One case replaces the flag update with a request. When the update is due, the destination is the program counter, and the current mode keeps a saved status copy, the block raises a restore request. It then passes the current flags through unchanged, so that the surrounding logic can reload the whole status word. The block is purely combinational.

Top module: `dp_alu`

## Requirements
- R1: The 4-bit opcode selects the operation as follows: 0 AND, 1 EOR, 2 SUB (a-b), 3 RSB (b-a), 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The arithmetic results are taken modulo 2^WIDTH.
- R2: The logical write operations produce the following results: AND gives a&b, EOR gives a^b, ORR gives a|b, MOV gives b, BIC gives a&~b and MVN gives ~b. Each asserts `result_we`.
- R3: TST (a&b), TEQ (a^b), CMP (a-b) and CMN (a+b) deassert `result_we` and update the flags whatever the value of `set_flags`.
- R4: The flag vector is packed as {N,Z,C,V}, bits 3 to 0. When a logical operation updates the flags, N is the result's top bit, Z is set for a zero result, C equals `shift_carry`, and V keeps its current value.
- R5: When ADD, ADC or CMN updates the flags, N and Z follow the result, C is the unsigned carry out of the top bit, and V is the signed overflow.
- R6: When SUB, RSB, SBC, RSC or CMP updates the flags, C is 1 exactly when no borrow occurs, and V is the signed overflow of the subtraction.
- R7: ADC adds the current C. SBC computes a-b-(1-C) and RSC computes b-a-(1-C), where C is the current carry flag (`flags_in` bit 1).
- R8: When `set_flags` is 0 and the operation writes a result, `flags_out` equals `flags_in` and `restore_req` is 0.
- R9: When a flag update is due and both `dest_is_pc` and `mode_has_saved` are 1, `restore_req` is 1 and `flags_out` equals `flags_in`. The result and its write enable are unaffected.
- R10: When `mode_has_saved` is 0, `restore_req` stays 0 and the flags are computed normally, even with `dest_is_pc` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (encoding in R1) |
| set_flags | input | 1 | Request a flag update for write operations |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Shifted second operand |
| shift_carry | input | 1 | Carry-out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| dest_is_pc | input | 1 | Destination register is the program counter |
| mode_has_saved | input | 1 | Current mode holds a saved status copy |
| result | output | WIDTH | Operation result |
| result_we | output | 1 | Result is to be written |
| flags_out | output | 4 | Next flags {N,Z,C,V} |
| restore_req | output | 1 | Request to reload status from the saved copy |

## Verification
A result write and a restore request can occur in the same evaluation. This happens with a writing operation that has `set_flags` high and the program counter as its destination. A compare can also raise the restore request with no write. The bench sweeps every opcode against every combination of the set-flags, destination and mode inputs. In each case it checks that the result and its write enable stay as computed, while the flags come back untouched and the request rises. A reduced 4-bit width allows every operand pair, carry input and shifter carry to be swept, so that every carry, borrow and overflow boundary is reached.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
        OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
        OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } dp_op_e;

    typedef enum logic {
        CLS_LOGIC = 1'b0,
        CLS_ARITH = 1'b1
    } dp_cls_e;

    typedef enum logic [1:0] {
        CIN_ZERO  = 2'd0,
        CIN_ONE   = 2'd1,
        CIN_CARRY = 2'd2
    } dp_cin_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } dp_flags_t;

    typedef struct packed {
        dp_cls_e cls;
        logic    writes;
        logic    swap;
        logic    inv;
        dp_cin_e cin_sel;
    } dp_ctrl_t;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dp_alu_pkg::*;
(
    input  dp_op_e   op,
    output dp_ctrl_t ctrl
);

    always_comb begin
        ctrl = '{cls: CLS_LOGIC, writes: 1'b1, swap: 1'b0, inv: 1'b0, cin_sel: CIN_ZERO};
        unique case (op)
            OP_AND, OP_EOR, OP_ORR, OP_MOV, OP_BIC, OP_MVN: begin
                ctrl.cls = CLS_LOGIC;
            end
            OP_TST, OP_TEQ: begin
                ctrl.cls    = CLS_LOGIC;
                ctrl.writes = 1'b0;
            end
            OP_ADD: ctrl.cls = CLS_ARITH;
            OP_ADC: begin
                ctrl.cls     = CLS_ARITH;
                ctrl.cin_sel = CIN_CARRY;
            end
            OP_CMN: begin
                ctrl.cls    = CLS_ARITH;
                ctrl.writes = 1'b0;
            end
            OP_SUB: begin
                ctrl.cls     = CLS_ARITH;
                ctrl.inv     = 1'b1;
                ctrl.cin_sel = CIN_ONE;
            end
            OP_CMP: begin
                ctrl.cls     = CLS_ARITH;
                ctrl.inv     = 1'b1;
                ctrl.cin_sel = CIN_ONE;
                ctrl.writes  = 1'b0;
            end
            OP_RSB: begin
                ctrl.cls     = CLS_ARITH;
                ctrl.swap    = 1'b1;
                ctrl.inv     = 1'b1;
                ctrl.cin_sel = CIN_ONE;
            end
            OP_SBC: begin
                ctrl.cls     = CLS_ARITH;
                ctrl.inv     = 1'b1;
                ctrl.cin_sel = CIN_CARRY;
            end
            OP_RSC: begin
                ctrl.cls     = CLS_ARITH;
                ctrl.swap    = 1'b1;
                ctrl.inv     = 1'b1;
                ctrl.cin_sel = CIN_CARRY;
            end
            default: ctrl.cls = CLS_LOGIC;
        endcase
    end

endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             swap,
    input  logic             inv,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x;
    logic [WIDTH-1:0] y_raw;
    logic [WIDTH-1:0] y;
    logic [WIDTH:0]   wide;

    always_comb begin
        x     = swap ? b : a;
        y_raw = swap ? a : b;
        y     = inv ? ~y_raw : y_raw;
        wide  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        sum   = wide[MSB:0];
        cout  = wide[WIDTH];
        ovf   = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end

endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dp_op_e           op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res
);

    always_comb begin
        unique case (op)
            OP_AND, OP_TST: res = a & b;
            OP_EOR, OP_TEQ: res = a ^ b;
            OP_ORR:         res = a | b;
            OP_MOV:         res = b;
            OP_BIC:         res = a & ~b;
            OP_MVN:         res = ~b;
            default:        res = '0;
        endcase
    end

endmodule

// File: rtl/dp_flagsel.sv
module dp_flagsel
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  dp_cls_e          cls,
    input  logic             update,
    input  logic             restore,
    input  logic [WIDTH-1:0] res,
    input  logic             cout,
    input  logic             ovf,
    input  logic             shc,
    input  dp_flags_t        fin,
    output dp_flags_t        fout
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        fout = fin;
        if (update && !restore) begin
            fout.n = res[MSB];
            fout.z = ~|res;
            if (cls == CLS_LOGIC) begin
                fout.c = shc;
                fout.v = fin.v;
            end else begin
                fout.c = cout;
                fout.v = ovf;
            end
        end
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             shift_carry,
    input  logic [3:0]       flags_in,
    input  logic             dest_is_pc,
    input  logic             mode_has_saved,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic [3:0]       flags_out,
    output logic             restore_req
);

    dp_op_e           op_e;
    dp_ctrl_t         ctrl;
    dp_flags_t        fin;
    dp_flags_t        fout;
    logic             cin;
    logic [WIDTH-1:0] arith_sum;
    logic [WIDTH-1:0] logic_res;
    logic             cout;
    logic             ovf;
    logic             update;

    assign op_e = dp_op_e'(op);
    assign fin  = dp_flags_t'(flags_in);

    dp_decode u_decode (
        .op   (op_e),
        .ctrl (ctrl)
    );

    always_comb begin
        unique case (ctrl.cin_sel)
            CIN_ONE:   cin = 1'b1;
            CIN_CARRY: cin = fin.c;
            default:   cin = 1'b0;
        endcase
    end

    dp_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (op_a),
        .b    (op_b),
        .swap (ctrl.swap),
        .inv  (ctrl.inv),
        .cin  (cin),
        .sum  (arith_sum),
        .cout (cout),
        .ovf  (ovf)
    );

    dp_logic #(.WIDTH(WIDTH)) u_logic (
        .op  (op_e),
        .a   (op_a),
        .b   (op_b),
        .res (logic_res)
    );

    always_comb begin
        update      = set_flags | ~ctrl.writes;
        restore_req = update & dest_is_pc & mode_has_saved;
        result      = (ctrl.cls == CLS_LOGIC) ? logic_res : arith_sum;
        result_we   = ctrl.writes;
    end

    dp_flagsel #(.WIDTH(WIDTH)) u_flagsel (
        .cls     (ctrl.cls),
        .update  (update),
        .restore (restore_req),
        .res     (result),
        .cout    (cout),
        .ovf     (ovf),
        .shc     (shift_carry),
        .fin     (fin),
        .fout    (fout)
    );

    assign flags_out = fout;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [3:0]       op,
    input logic             set_flags,
    input logic             shift_carry,
    input logic [3:0]       flags_in,
    input logic             dest_is_pc,
    input logic             mode_has_saved,
    input logic [WIDTH-1:0] result,
    input logic             result_we,
    input logic [3:0]       flags_out,
    input logic             restore_req
);

    localparam int MSB = WIDTH - 1;

    logic is_cmp;
    logic is_logic;
    logic upd;

    always_comb begin
        is_cmp   = (op[3:2] == 2'b10);
        is_logic = (op == 4'd0) || (op == 4'd1) || (op == 4'd8) || (op == 4'd9) || (op >= 4'd12);
        upd      = set_flags || is_cmp;

        // R3
        if (is_cmp) begin
            cmp_no_write_chk: assert (!result_we) else $error("compare op wrote a result");
        end

        // R8
        if (!set_flags && !is_cmp) begin
            flags_hold_chk: assert (flags_out == flags_in && !restore_req) else $error("flags changed without S");
        end

        // R9
        if (restore_req) begin
            restore_hold_chk: assert (flags_out == flags_in && dest_is_pc && mode_has_saved) else $error("restore with bad flags");
        end

        // R10
        if (!mode_has_saved) begin
            no_saved_no_restore_chk: assert (!restore_req) else $error("restore without saved copy");
        end

        // R4
        if (upd && !restore_req) begin
            nz_track_chk: assert (flags_out[3] == result[MSB] && flags_out[2] == (result == '0)) else $error("N/Z mismatch");
        end

        // R4
        if (upd && !restore_req && is_logic) begin
            logic_cv_chk: assert (flags_out[1] == shift_carry && flags_out[0] == flags_in[0]) else $error("logical C/V mismatch");
        end
    end

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_dp_alu_chk (
    .op             (op),
    .set_flags      (set_flags),
    .shift_carry    (shift_carry),
    .flags_in       (flags_in),
    .dest_is_pc     (dest_is_pc),
    .mode_has_saved (mode_has_saved),
    .result         (result),
    .result_we      (result_we),
    .flags_out      (flags_out),
    .restore_req    (restore_req)
);

// File: tb/test_dp_alu.sv
module test_dp_alu;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;
    localparam int HALF = 1 << (W - 1);

    logic         clk = 1'b0;
    logic [3:0]   op;
    logic         set_flags;
    logic [W-1:0] op_a;
    logic [W-1:0] op_b;
    logic         shift_carry;
    logic [3:0]   flags_in;
    logic         dest_is_pc;
    logic         mode_has_saved;
    logic [W-1:0] result;
    logic         result_we;
    logic [3:0]   flags_out;
    logic         restore_req;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dp_alu #(.WIDTH(W)) i_dp_alu (
        .op             (op),
        .set_flags      (set_flags),
        .op_a           (op_a),
        .op_b           (op_b),
        .shift_carry    (shift_carry),
        .flags_in       (flags_in),
        .dest_is_pc     (dest_is_pc),
        .mode_has_saved (mode_has_saved),
        .result         (result),
        .result_we      (result_we),
        .flags_out      (flags_out),
        .restore_req    (restore_req)
    );

    function automatic int sx(input int v);
        return (v >= HALF) ? v - (1 << W) : v;
    endfunction

    task automatic run_one(input int o, input int a, input int b, input int fl,
                           input int sc, input int s, input int dpc, input int hs,
                           input string tag);
        int r, c, v, u, sv, cin, nb;
        int e_we, e_rst, e_fl;
        bit is_logic, upd;
        cin = (fl >> 1) & 1;
        nb  = 1 - cin;
        is_logic = 1'b1;
        c = 0; v = 0; r = 0;
        case (o)
            0, 8:  r = a & b;
            1, 9:  r = a ^ b;
            12:    r = a | b;
            13:    r = b;
            14:    r = a & ~b & MASK;
            15:    r = ~b & MASK;
            default: begin
                is_logic = 1'b0;
                case (o)
                    4, 11: begin u = a + b;       sv = sx(a) + sx(b);       c = (u > MASK); end
                    5:     begin u = a + b + cin; sv = sx(a) + sx(b) + cin; c = (u > MASK); end
                    2, 10: begin u = a - b;       sv = sx(a) - sx(b);       c = (a >= b); end
                    3:     begin u = b - a;       sv = sx(b) - sx(a);       c = (b >= a); end
                    6:     begin u = a - b - nb;  sv = sx(a) - sx(b) - nb;  c = (a >= b + nb); end
                    default: begin u = b - a - nb; sv = sx(b) - sx(a) - nb; c = (b >= a + nb); end
                endcase
                r = u & MASK;
                v = (sv > HALF - 1 || sv < -HALF) ? 1 : 0;
            end
        endcase
        e_we  = (o >= 8 && o <= 11) ? 0 : 1;
        upd   = (s != 0) || (e_we == 0);
        e_rst = (upd && dpc != 0 && hs != 0) ? 1 : 0;
        if (!upd || e_rst != 0) e_fl = fl;
        else if (is_logic) e_fl = (((r >> (W-1)) & 1) << 3) | ((r == 0) << 2) | (sc << 1) | (fl & 1);
        else e_fl = (((r >> (W-1)) & 1) << 3) | ((r == 0) << 2) | (c << 1) | v;

        @(negedge clk);
        op = o[3:0]; op_a = a[W-1:0]; op_b = b[W-1:0]; flags_in = fl[3:0];
        shift_carry = sc[0]; set_flags = s[0]; dest_is_pc = dpc[0]; mode_has_saved = hs[0];
        #2;
        checks++;
        if ((e_we != 0 && int'(result) != r) || int'(result_we) != e_we ||
            int'(flags_out) != e_fl || int'(restore_req) != e_rst) begin
            errors++;
            $display("FAIL %s op=%0d a=%0d b=%0d fl=%h sc=%0d s=%0d pc=%0d hs=%0d: got res=%0d we=%0d fl=%h rst=%0d exp res=%0d we=%0d fl=%h rst=%0d",
                     tag, o, a, b, fl, sc, s, dpc, hs, result, result_we, flags_out, restore_req,
                     r, e_we, e_fl, e_rst);
        end
    endtask

    function automatic string tag_for(input int o, input int s);
        if (o >= 8 && o <= 11) return "R3";
        if (s == 0) return "R8";
        if (o <= 1 || o >= 12) return "R2 R4";
        if (o == 4) return "R1 R5";
        if (o == 5) return "R5 R7";
        if (o == 2 || o == 3) return "R1 R6";
        return "R6 R7";
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // initial state: all-zero inputs, AND without S, flags pass (R8)
        run_one(0, 0, 0, 0, 0, 0, 0, 0, "R8");

        // exhaustive sweep of opcodes, operands, carry in, shifter carry and S
        for (int o = 0; o < 16; o++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    for (int k = 0; k < 8; k++) begin
                        int cf, sc, s, fl;
                        cf = k & 1; sc = (k >> 1) & 1; s = (k >> 2) & 1;
                        fl = (((cf ^ b) & 1) << 3) | (((a ^ (b >> 1)) & 1) << 2) | (cf << 1) | ((a >> 1 ^ b >> 2 ^ sc) & 1);
                        run_one(o, a, b, fl, sc, s, 0, 1, tag_for(o, s));
                    end

        // restore request against destination / saved-copy / S combinations
        for (int o = 0; o < 16; o++)
            for (int m = 0; m < 8; m++) begin
                int s, dpc, hs;
                s = m & 1; dpc = (m >> 1) & 1; hs = (m >> 2) & 1;
                run_one(o, 9, 7, 4'b0110, 1, s, dpc, hs, (hs == 0) ? "R10" : "R9");
                run_one(o, 0, 0, 4'b1001, 0, s, dpc, hs, (hs == 0) ? "R10" : "R9");
            end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule